// File: doc/BRIEF.md
# Stochastic Probability-Table Neuron

This block is a single weightless neuron. Its binary input lines are taken together as an address into a small table of firing probabilities. On each cycle that carries a valid input sample, the addressed probability is compared with a fresh pseudo-random number. The neuron emits a 1 with exactly that probability. A run of such samples forms an output spike train, and the block counts the ones in it.

A host port writes and reads the probability table. A start pulse sets the train length and clears the count. When the programmed number of samples has been drawn, the block pulses done and presents the ones count. Short trains suit training, where the noise helps the network generalise. Long trains suit recall, where the ones count gives a low-noise estimate of the firing probability.

Top module: `prob_neuron`

## Requirements
- R1: The 6-bit `in_bits` value, read as an unsigned number, selects one of 64 table entries of 16 bits each. All entries read 0 after reset.
- R2: The random source is a 32-bit Fibonacci LFSR. Each step shifts the state left by one and feeds bit31^bit21^bit1^bit0 into bit 0. It steps only on a draw. `seed_load` replaces the state with `seed_val`, or with 32'h5EED1234 when `seed_val` is 0. Reset also sets 32'h5EED1234.
- R3: A draw fires when the LFSR's low 16 bits, taken before the step, are strictly less than the addressed entry (unsigned compare). An entry of 0 never fires.
- R4: `spike_valid` is high, and `spike_out` carries the drawn bit, in the cycle after each draw edge. At all other times `spike_valid` is low and `spike_out` is 0.
- R5: `start` loads `train_len`, clears the sample and ones counters, and raises `busy` when the length is nonzero. A draw happens on an edge where `busy` and `in_valid` are high and `start` is low. A start in the same cycle as `in_valid` draws nothing.
- R6: `done` is a one-cycle pulse in the cycle after the final draw edge, which is the same cycle as the last `spike_valid`. In that cycle `ones_count` holds the number of ones in the train and `busy` is low. `ones_count` holds its value until the next done.
- R7: A start with `train_len` = 0 gives `done` in the next cycle with `ones_count` = 0, and `busy` stays low.
- R8: A host write (`host_we`, `host_addr`, `host_wdata`) updates the entry at the edge. A draw on that same edge still uses the old value; draws from the next cycle on use the new value.
- R9: `host_rdata` shows the entry at `host_addr` as it was at the previous edge, one cycle of latency.
- R10: `in_valid` while not busy is ignored. No spike is flagged and the LFSR does not step, so the next train draws from an unchanged sequence.
- R11: Over a 4000-sample train on an entry of 0x4000, the ones count lies within 120 of 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Replace LFSR state |
| seed_val | input | 32 | New LFSR state (0 selects the default) |
| in_bits | input | 6 | Binary input lines, table address |
| in_valid | input | 1 | Input sample present this cycle |
| start | input | 1 | Begin a new train |
| train_len | input | 16 | Samples in the train, sampled on start |
| host_we | input | 1 | Host table write enable |
| host_addr | input | 6 | Host table address for write and read |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| spike_out | output | 1 | Drawn output bit |
| spike_valid | output | 1 | spike_out carries a sample |
| busy | output | 1 | Train in progress |
| done | output | 1 | Train finished, one-cycle pulse |
| ones_count | output | 16 | Ones in the last finished train |

## Verification
A draw on edge k shows on `spike_out` and `spike_valid` after edge k. `done`, `busy` and `ones_count` follow the final draw with the same one-edge delay. `host_rdata` also lags its address by one edge. The bench therefore drives every input at a falling edge, lets exactly one rising edge pass, and compares all outputs at the next falling edge. It predicts each value from a bench-side LFSR and table model that is advanced only on the cycles the requirements call draws. A host write that coincides with a draw is applied to the model only after the expected bit for that draw has been formed, which puts the one-cycle write latency directly into the prediction.

// File: rtl/pn_pkg.sv
package pn_pkg;
   // Default LFSR state used at reset and when a zero seed is offered
   localparam logic [31:0] PN_SEED_DEFAULT = 32'h5EED1234;

   // Result of one draw as passed from the comparator to the controller
   typedef struct packed {
      logic take;
      logic fire;
   } pn_draw_t;
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
   parameter int          W     = 32,
   parameter int          OUT_W = 16,
   parameter logic [W-1:0] SEED  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [W-1:0]     load_val,
   input  logic             step,
   output logic [OUT_W-1:0] rnd
);
   logic [W-1:0] state_q;
   logic         fb;

   if (OUT_W > W) begin : g_bad_out
      $error("pn_lfsr: output wider than state");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("pn_lfsr: seed must be nonzero");
   end

   // Tap set chosen by width (maximal-length polynomials)
   if (W == 32) begin : g_w32
      assign fb = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];
   end else if (W == 24) begin : g_w24
      assign fb = state_q[23] ^ state_q[22] ^ state_q[21] ^ state_q[16];
   end else if (W == 16) begin : g_w16
      assign fb = state_q[15] ^ state_q[14] ^ state_q[12] ^ state_q[3];
   end else begin : g_wbad
      $error("pn_lfsr: unsupported width");
      assign fb = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (load) begin
         state_q <= (load_val == '0) ? SEED : load_val;
      end else if (step) begin
         state_q <= {state_q[W-2:0], fb};
      end
   end

   assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/pn_prob_mem.sv
module pn_prob_mem #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] host_rdata,
   input  logic [AW-1:0] draw_addr,
   output logic [DW-1:0] draw_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         host_rdata <= '0;
      end else begin
         if (we) mem_q[host_addr] <= wdata;
         host_rdata <= mem_q[host_addr];
      end
   end

   // Combinational draw port: a write at this edge is seen from the next cycle
   assign draw_data = mem_q[draw_addr];
endmodule

// File: rtl/pn_train_ctrl.sv
module pn_train_ctrl
   import pn_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   input  logic             in_valid,
   input  logic             fire,
   output pn_draw_t         draw,
   output logic             busy,
   output logic             spike_out,
   output logic             spike_valid,
   output logic             done,
   output logic [LEN_W-1:0] ones_count,
   output logic [LEN_W-1:0] len_cur
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] ones_q;
   logic [LEN_W-1:0] cnt_nx;
   logic [LEN_W-1:0] ones_nx;

   assign draw.take = busy && in_valid && !start;
   assign draw.fire = fire;
   assign cnt_nx    = cnt_q + 1'b1;
   assign ones_nx   = ones_q + {{(LEN_W-1){1'b0}}, fire};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_cur     <= '0;
         cnt_q       <= '0;
         ones_q      <= '0;
         busy        <= 1'b0;
         done        <= 1'b0;
         spike_out   <= 1'b0;
         spike_valid <= 1'b0;
         ones_count  <= '0;
      end else if (start) begin
         len_cur     <= len;
         cnt_q       <= '0;
         ones_q      <= '0;
         busy        <= (len != '0);
         done        <= (len == '0);
         spike_out   <= 1'b0;
         spike_valid <= 1'b0;
         if (len == '0) ones_count <= '0;
      end else begin
         done        <= 1'b0;
         spike_valid <= draw.take;
         spike_out   <= draw.take && fire;
         if (draw.take) begin
            cnt_q  <= cnt_nx;
            ones_q <= ones_nx;
            if (cnt_nx == len_cur) begin
               busy       <= 1'b0;
               done       <= 1'b1;
               ones_count <= ones_nx;
            end
         end
      end
   end
endmodule

// File: rtl/prob_neuron.sv
module prob_neuron
   import pn_pkg::*;
#(
   parameter int          N_IN   = 6,
   parameter int          P_W    = 16,
   parameter int          RND_W  = 32,
   parameter int          LEN_W  = 16,
   parameter logic [31:0] SEED   = PN_SEED_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_load,
   input  logic [RND_W-1:0] seed_val,
   input  logic [N_IN-1:0]  in_bits,
   input  logic             in_valid,
   input  logic             start,
   input  logic [LEN_W-1:0] train_len,
   input  logic             host_we,
   input  logic [N_IN-1:0]  host_addr,
   input  logic [P_W-1:0]   host_wdata,
   output logic [P_W-1:0]   host_rdata,
   output logic             spike_out,
   output logic             spike_valid,
   output logic             busy,
   output logic             done,
   output logic [LEN_W-1:0] ones_count
);
   if (N_IN < 1 || N_IN > 10) begin : g_bad_nin
      $error("prob_neuron: N_IN out of range");
   end
   if (RND_W < P_W) begin : g_bad_rnd
      $error("prob_neuron: random word narrower than probability");
   end

   logic [P_W-1:0]   rnd;
   logic [P_W-1:0]   draw_p;
   logic             fire;
   pn_draw_t         draw;
   logic [LEN_W-1:0] len_cur;

   pn_lfsr #(.W(RND_W), .OUT_W(P_W), .SEED(SEED[RND_W-1:0])) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (seed_load),
      .load_val (seed_val),
      .step     (draw.take),
      .rnd      (rnd)
   );

   pn_prob_mem #(.AW(N_IN), .DW(P_W)) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (host_we),
      .host_addr  (host_addr),
      .wdata      (host_wdata),
      .host_rdata (host_rdata),
      .draw_addr  (in_bits),
      .draw_data  (draw_p)
   );

   // Strict unsigned compare: probability p/2^P_W of a one
   assign fire = (rnd < draw_p);

   pn_train_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .len         (train_len),
      .in_valid    (in_valid),
      .fire        (fire),
      .draw        (draw),
      .busy        (busy),
      .spike_out   (spike_out),
      .spike_valid (spike_valid),
      .done        (done),
      .ones_count  (ones_count),
      .len_cur     (len_cur)
   );
endmodule

module pn_checker #(
   parameter int P_W   = 16,
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             take,
   input logic             start,
   input logic             seed_load,
   input logic [P_W-1:0]   draw_p,
   input logic [P_W-1:0]   rnd,
   input logic             spike_out,
   input logic             spike_valid,
   input logic             busy,
   input logic             done,
   input logic [LEN_W-1:0] ones_count,
   input logic [LEN_W-1:0] len_cur
);
   // R3: a zero entry never produces a one
   a_r3_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (take && draw_p == '0) |=> !spike_out);

   // R4: a flagged spike always follows a draw edge
   a_r4_valid_follows_draw: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> spike_valid);

   // R4: no spike bit without its valid flag
   a_r4_spike_gated: assert property (@(posedge clk) disable iff (!rst_n)
      spike_out |-> spike_valid);

   // R5: start never yields a sample in the next cycle
   a_r5_start_no_spike: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !spike_valid);

   // R6: done only when idle, and the count never exceeds the length
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && ones_count <= len_cur));

   // R10: random word holds when neither drawn nor reseeded
   a_r10_rnd_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !seed_load) |=> $stable(rnd));
endmodule

bind prob_neuron pn_checker #(.P_W(P_W), .LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .take        (draw.take),
   .start       (start),
   .seed_load   (seed_load),
   .draw_p      (draw_p),
   .rnd         (rnd),
   .spike_out   (spike_out),
   .spike_valid (spike_valid),
   .busy        (busy),
   .done        (done),
   .ones_count  (ones_count),
   .len_cur     (len_cur)
);

// File: tb/prob_neuron_test.sv
module prob_neuron_test;
   localparam time TCK = 8ns;
   localparam logic [31:0] DEF_SEED = 32'h5EED1234;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [31:0] seed_val = '0;
   logic [5:0]  in_bits = '0;
   logic        in_valid = 1'b0;
   logic        start = 1'b0;
   logic [15:0] train_len = '0;
   logic        host_we = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        spike_out, spike_valid, busy, done;
   logic [15:0] ones_count;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   logic [31:0] m_lfsr = DEF_SEED;
   logic [15:0] m_mem [64];
   logic        m_busy = 1'b0;
   int          m_len = 0, m_cnt = 0, m_ones = 0, m_res = 0;

   always #(TCK/2) clk = ~clk;

   prob_neuron uut (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
      .in_bits(in_bits), .in_valid(in_valid), .start(start), .train_len(train_len),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .spike_out(spike_out), .spike_valid(spike_valid),
      .busy(busy), .done(done), .ones_count(ones_count)
   );

   function automatic logic [31:0] lfsr_next(logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One clock: inputs set at a falling edge, outputs checked at the next one
   task automatic cyc(bit v, logic [5:0] a, bit st, logic [15:0] len,
                      bit we, logic [5:0] wa, logic [15:0] wd);
      bit e_sv = 0, e_sp = 0, e_done = 0;
      in_valid = v; in_bits = a; start = st; train_len = len;
      host_we = we; host_addr = wa; host_wdata = wd;
      if (st) begin
         m_busy = (len != 0); m_len = len; m_cnt = 0; m_ones = 0;
         if (len == 0) begin e_done = 1; m_res = 0; end
      end else if (v && m_busy) begin
         e_sp = (m_lfsr[15:0] < m_mem[a]);  // old entry even if written now
         e_sv = 1;
         m_lfsr = lfsr_next(m_lfsr);
         m_cnt++; m_ones += int'(e_sp);
         if (m_cnt == m_len) begin e_done = 1; m_busy = 0; m_res = m_ones; end
      end
      if (we) m_mem[wa] = wd;
      @(posedge clk); @(negedge clk);
      in_valid = 0; start = 0; host_we = 0;
      check(spike_valid == e_sv, "R4 spike_valid", spike_valid, e_sv);
      if (e_sv) check(spike_out == e_sp, "R1 R3 spike_out", spike_out, e_sp);
      else      check(spike_out == 0, "R4 spike_out idle", spike_out, 0);
      check(done == e_done, "R6 done", done, e_done);
      check(busy == m_busy, "R5 busy", busy, m_busy);
      if (e_done) check(ones_count == 16'(m_res), "R6 R7 ones_count", ones_count, m_res);
   endtask

   task automatic hwrite(logic [5:0] a, logic [15:0] d);
      cyc(0, 0, 0, 0, 1, a, d);
   endtask

   task automatic hread(logic [5:0] a);
      cyc(0, 0, 0, 0, 0, a, 0);
      check(host_rdata == m_mem[a], "R9 host_rdata", host_rdata, m_mem[a]);
   endtask

   task automatic seed(logic [31:0] s);
      seed_load = 1; seed_val = s;
      @(posedge clk); @(negedge clk);
      seed_load = 0;
      m_lfsr = (s == 0) ? DEF_SEED : s;
   endtask

   task automatic train(int len, bit rnd_addr, logic [5:0] fixed, bit gaps);
      cyc(0, 0, 1, 16'(len), 0, 0, 0);
      for (int i = 0; i < len; i++) begin
         if (gaps && ($urandom % 4 == 0)) cyc(0, 0, 0, 0, 0, 0, 0);
         cyc(1, rnd_addr ? 6'($urandom) : fixed, 0, 0, 0, 0, 0);
      end
   endtask

   initial begin
      #(TCK * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd42));
      for (int i = 0; i < 64; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state (R1, R6)
      check(spike_valid == 0 && done == 0 && busy == 0, "R4 reset outputs", {spike_valid, done, busy}, 0);
      check(ones_count == 0, "R6 reset count", ones_count, 0);
      hread(6'd17);   // R1: table cleared

      // R10 before any seed: idle valid must not step the default sequence
      for (int i = 0; i < 5; i++) cyc(1, 6'($urandom), 0, 0, 0, 0, 0);
      hwrite(6'd3, 16'h8000);
      train(20, 0, 6'd3, 0);

      seed(32'hC3A5_0F1E);
      // program table: random entries, with both extremes
      for (int i = 0; i < 64; i++) begin
         logic [15:0] d = 16'($urandom);
         if (i == 0) d = 16'h0000;
         if (i == 63) d = 16'hFFFF;
         if (i == 9) d = 16'h0000;
         hwrite(6'(i), d);
      end
      for (int i = 0; i < 8; i++) hread(6'($urandom));  // R9
      hread(6'd0); hread(6'd63);

      train(200, 1, 0, 1);          // main function, random addresses, gaps
      train(50, 0, 6'd0, 0);        // R3 zero entry
      train(50, 0, 6'd63, 0);       // R3 full-scale entry
      train(1, 1, 0, 0);            // single sample train

      // R7 zero-length train
      cyc(0, 0, 1, 16'd0, 0, 0, 0);

      // R5 start with in_valid in the same cycle: no draw
      cyc(1, 6'd5, 1, 16'd3, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 6'($urandom), 0, 0, 0, 0, 0);

      // R8 write coinciding with a draw on the same entry
      cyc(0, 0, 1, 16'd4, 0, 0, 0);
      cyc(1, 6'd9, 0, 0, 1, 6'd9, 16'hFFFF);   // uses old 0
      cyc(1, 6'd9, 0, 0, 0, 0, 0);             // uses new
      cyc(1, 6'd9, 0, 0, 1, 6'd9, 16'h0000);
      cyc(1, 6'd9, 0, 0, 0, 0, 0);

      // R10 idle valid after a train, then sequence continues
      for (int i = 0; i < 6; i++) cyc(1, 6'($urandom), 0, 0, 0, 0, 0);
      train(40, 1, 0, 0);

      // R2 zero seed selects the default
      seed(32'h0);
      train(30, 1, 0, 0);
      seed(32'h1357_9BDF);

      // R11 long train on a quarter-probability entry
      hwrite(6'd5, 16'h4000);
      train(4000, 0, 6'd5, 0);
      check(m_res >= 880 && m_res <= 1120, "R11 mean", m_res, 1000);
      check(ones_count >= 880 && ones_count <= 1120, "R11 ones_count", ones_count, 1000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule